// File: doc/BRIEF.md
# Prescaled Down-Counting Event Timer

This block is an eight-bit down-counter with a seven-bit prescaler in front of it. Software reaches it through a small byte-wide register port. The count pulses come from one of three sources: a single-cycle internal cycle tick, that tick gated by an external pin, or falling edges on the external pin alone. A fourth setting stops all counting. The selected source advances the prescaler. A programmable tap on the prescaler then decides which source events also step the counter down.

Each time the counter steps from one to zero, it sets a sticky request flag in the control register. The interrupt output is the flag qualified by a mask bit. A low-power entry input and a warm reset both drop the flag and set the mask. Software can read the counter at any moment without disturbing it, and can load the counter at any moment.

Top module: `evt_timer`

## Requirements
- R1: Each count step lowers the counter by one. From 0x00 it wraps to 0xFF and keeps counting.
- R2: The request flag is control bit 7. A count step from 0x01 to 0x00 sets it, and a control write with bit 7 = 1 sets it. Only a control write with bit 7 = 0 clears it. If a hardware set and a software clear fall in the same cycle, the flag ends up set.
- R3: `irq_o` is high exactly when the flag (bit 7) is 1 and the mask (bit 6) is 0.
- R4: Control bits 2:0 hold a tap code n. The counter steps once per 2^n source events, on the event that wraps the low n prescaler bits from all-ones to zero. Code 0 steps on every event.
- R5: A control write with bit 3 = 1 clears the prescaler to zero, and this clear wins over a source event in the same cycle. Bit 3 always reads 0.
- R6: With control bits 5:4 = 00, every cycle with `tick_i` high is a source event.
- R7: With bits 5:4 = 01, `tick_i` is a source event only while the synchronized pin is high. The pin is seen two clock edges after it is sampled.
- R8: With bits 5:4 = 10, there are no source events. The counter and prescaler hold.
- R9: With bits 5:4 = 11, each falling edge of the synchronized pin is one source event, and `tick_i` is ignored.
- R10: While `por_n` is low, the counter becomes 0xFF, the prescaler 0x7F and the control register 0x40. So the first source event after power-on steps the counter for any tap code.
- R11: A cycle with `rst_n` low clears bit 7 and sets bit 6. Bits 5:0, the counter and the prescaler keep their values.
- R12: A cycle with `stop_i` high clears bit 7 and sets bit 6.
- R13: Offset 0 (`addr_i` = 0) is the counter and offset 1 is the control register. A counter write loads `wdata_i` and wins over a count step in the same cycle. `rdata_o` shows the addressed register while `rd_i` is high and is 0 otherwise. Reads change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_n | input | 1 | Synchronous warm reset of flag and mask, active low |
| tick_i | input | 1 | Single-cycle internal cycle-clock pulse |
| ext_i | input | 1 | Asynchronous external count/gate pin |
| stop_i | input | 1 | Low-power entry strobe |
| addr_i | input | 1 | Register select: 0 counter, 1 control |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a hardware flag set that lands in the same cycle as a software clear. That needs the counter sitting at 0x01, a qualifying tap event, and a control write all at one edge. The stimulus loads 0x01 and clears the prescaler. It then issues the control write together with a tick under tap code 0, so the collision is forced. A long random phase then mixes writes, pin activity and every mode. Throughout, a behavioural model tracks the pin history and is compared on each clock, which also covers the two-edge pin latency of the gated and edge modes.

// File: rtl/evt_timer.sv
`timescale 1ns/1ps
module evt_timer #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 7
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             ext_i,
  input  logic             stop_i,
  input  logic             addr_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             irq_o
);
  localparam int SEL_W = 3;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] tap_mask;
  logic [2:0]       pin_q;
  logic [1:0]       mode_q;
  logic [SEL_W-1:0] sel_q;
  logic             flag_q, mask_q;
  logic             src_evt, step, underflow;

  wire cnt_wr = wr_i & ~addr_i;
  wire ctl_wr = wr_i & addr_i;
  wire pre_clr = ctl_wr & wdata_i[3];
  wire pin_now = pin_q[1];
  wire pin_old = pin_q[2];

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) pin_q <= '0;
    else        pin_q <= {pin_q[1:0], ext_i};

  always_comb
    case (mode_q)
      2'b00:   src_evt = tick_i;
      2'b01:   src_evt = tick_i & pin_now;
      2'b10:   src_evt = 1'b0;
      default: src_evt = pin_old & ~pin_now;
    endcase

  always_comb
    for (int i = 0; i < PRE_W; i++) tap_mask[i] = (i < int'(sel_q));

  assign step      = src_evt & (&(pre_q | ~tap_mask));
  assign underflow = step & ~cnt_wr & (cnt_q == CNT_ONE);

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)       pre_q <= '1;
    else if (pre_clr) pre_q <= '0;
    else if (src_evt) pre_q <= pre_q + PRE_W'(1);

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)      cnt_q <= '1;
    else if (cnt_wr) cnt_q <= wdata_i;
    else if (step)   cnt_q <= cnt_q - CNT_ONE;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      flag_q <= 1'b0;
      mask_q <= 1'b1;
      mode_q <= 2'b00;
      sel_q  <= '0;
    end else begin
      if (ctl_wr) begin
        mode_q <= wdata_i[5:4];
        sel_q  <= wdata_i[2:0];
      end
      if (!rst_n || stop_i) begin
        flag_q <= 1'b0;
        mask_q <= 1'b1;
      end else begin
        if (ctl_wr) begin
          flag_q <= wdata_i[7];
          mask_q <= wdata_i[6];
        end
        if (underflow) flag_q <= 1'b1;
      end
    end

  wire [7:0] ctl_view = {flag_q, mask_q, mode_q, 1'b0, sel_q};

  assign rdata_o = !rd_i ? '0 : (addr_i ? CNT_W'(ctl_view) : cnt_q);
  assign irq_o   = flag_q & ~mask_q;

  a_r1_wrap: assert property (@(posedge clk) disable iff (!por_n)
    step && !cnt_wr && cnt_q == '0 |=> cnt_q == '1);
  a_r2_hw_set: assert property (@(posedge clk) disable iff (!por_n)
    underflow && rst_n && !stop_i |=> flag_q);
  a_r2_sticky: assert property (@(posedge clk) disable iff (!por_n)
    flag_q && !ctl_wr && rst_n && !stop_i |=> flag_q);
  a_r4_pre_step: assert property (@(posedge clk) disable iff (!por_n)
    src_evt && !pre_clr |=> pre_q == $past(pre_q) + PRE_W'(1));
  a_r5_bit3_zero: assert property (@(posedge clk) disable iff (!por_n)
    rd_i && addr_i |-> rdata_o[3] == 1'b0);
  a_r8_hold: assert property (@(posedge clk) disable iff (!por_n)
    mode_q == 2'b10 && !cnt_wr |=> $stable(cnt_q));
  a_r11_warm: assert property (@(posedge clk) disable iff (!por_n)
    !rst_n |=> !irq_o);
  a_r12_stop: assert property (@(posedge clk) disable iff (!por_n)
    stop_i |=> !irq_o);
  a_r13_load: assert property (@(posedge clk) disable iff (!por_n)
    cnt_wr |=> cnt_q == $past(wdata_i));
endmodule

// File: tb/evt_timer_tb_top.sv
`timescale 1ns/1ps
module evt_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, por_n = 0, rst_n = 1, tick_i = 0, ext_i = 0, stop_i = 0;
  logic addr_i = 0, wr_i = 0, rd_i = 1;
  logic [7:0] wdata_i = 0, rdata_o;
  logic irq_o;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R10";

  int m_cnt, m_pre, m_mode, m_sel;
  bit m_flag, m_mask;
  bit hist[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_timer dut_i (.clk(clk), .por_n(por_n), .rst_n(rst_n), .tick_i(tick_i),
    .ext_i(ext_i), .stop_i(stop_i), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o));

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", req, got, exp, cycles);
    end
  endtask

  function automatic int model_read();
    if (!rd_i) return 0;
    if (addr_i) return (int'(m_flag) << 7) | (int'(m_mask) << 6) | (m_mode << 4) | m_sel;
    return m_cnt;
  endfunction

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    cycles++;
    if (!por_n) begin
      m_cnt = 255; m_pre = 127; m_mode = 0; m_sel = 0; m_flag = 0; m_mask = 1;
      hist = '{0, 0, 0};
    end else begin
      bit src, stp, hw, cw, kw;
      int span;
      cw = wr_i && !addr_i;
      kw = wr_i && addr_i;
      case (m_mode)
        0: src = tick_i;
        1: src = tick_i && hist[1];
        2: src = 0;
        default: src = hist[2] && !hist[1];
      endcase
      span = 1 << m_sel;
      stp = src && ((m_pre % span) == span - 1);
      hw = stp && !cw && m_cnt == 1;
      if (kw && wdata_i[3]) m_pre = 0;
      else if (src) m_pre = (m_pre + 1) % 128;
      if (cw) m_cnt = wdata_i;
      else if (stp) m_cnt = (m_cnt + 255) % 256;
      if (kw) begin m_mode = wdata_i[5:4]; m_sel = wdata_i[2:0]; end
      if (!rst_n || stop_i) begin m_flag = 0; m_mask = 1; end
      else begin
        if (kw) begin m_flag = wdata_i[7]; m_mask = wdata_i[6]; end
        if (hw) m_flag = 1;
      end
      hist.push_front(ext_i);
      void'(hist.pop_back());
    end
  end

  // every-cycle comparison, away from the rising edge
  always @(negedge clk) if (por_n) begin
    check({cur_req, " read"}, int'(rdata_o), model_read());
    check({cur_req, " irq"}, int'(irq_o), int'(m_flag && !m_mask));
  end

  task automatic cyc(bit tk, bit ex, bit w = 0, bit a = 0, logic [7:0] d = 0,
                     bit st = 0, bit rs = 1);
    @(negedge clk); #1;
    tick_i = tk; ext_i = ex; wr_i = w; wdata_i = d; stop_i = st; rst_n = rs;
    addr_i = w ? a : ~addr_i;
  endtask

  task automatic wr(bit a, logic [7:0] d); cyc(0, ext_i, 1, a, d); endtask

  task automatic peek(bit a, string req, int exp);
    @(negedge clk); #1;
    wr_i = 0; tick_i = 0; stop_i = 0; rst_n = 1; addr_i = a;
    #1 check({req, " direct"}, int'(rdata_o), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 por_n = 1;
    cur_req = "R10";
    peek(0, "R10", 8'hFF);
    peek(1, "R10", 8'h40);
    wr(1, 8'h47);                 // mask set, internal tick, tap 7, prescaler untouched
    cyc(1, 0);
    peek(0, "R10", 8'hFE);        // first event after power-on steps the counter

    cur_req = "R1 R2 R3 R6";
    wr(1, 8'h08); wr(0, 8'h03);
    repeat (6) cyc(1, 0);
    peek(1, "R2", 8'h80);
    peek(0, "R1", 8'hFD);
    repeat (4) cyc(1, 0);
    wr(1, 8'h00);
    peek(1, "R2", 8'h00);

    cur_req = "R4";
    for (int s = 0; s < 8; s++) begin
      wr(1, 8'h48 | 8'(s)); wr(0, 8'h80);
      repeat (300) cyc(1'($urandom_range(0, 1)), 0);
    end
    wr(1, 8'h4A); wr(0, 8'h80);
    repeat (12) cyc(1, 0);
    peek(0, "R4", 8'h7D);

    cur_req = "R5";
    wr(1, 8'h43); repeat (5) cyc(1, 0);
    cyc(1, 0, 1, 1, 8'h4B);
    peek(1, "R5", 8'h43);
    repeat (20) cyc(1, 0);

    cur_req = "R7";
    wr(1, 8'h50);
    for (int i = 0; i < 200; i++) cyc(1'($urandom_range(0, 1)), (i / 7) % 2 == 1);

    cur_req = "R8";
    wr(1, 8'h60); wr(0, 8'h22);
    for (int i = 0; i < 60; i++) cyc(1, i % 2 == 0);
    peek(0, "R8", 8'h22);

    cur_req = "R9";
    wr(1, 8'h70); wr(0, 8'h05);
    for (int i = 0; i < 40; i++) cyc(1'($urandom_range(0, 1)), (i / 3) % 2 == 1);

    cur_req = "R11";
    wr(1, 8'h85);
    cyc(0, 0, 0, 0, 0, 0, 0);
    peek(1, "R11", 8'h45);

    cur_req = "R12";
    wr(1, 8'h80);
    cyc(0, 0, 0, 0, 0, 1);
    peek(1, "R12", 8'h40);

    cur_req = "R13";
    wr(1, 8'h08);
    cyc(1, 0, 1, 0, 8'h01);
    peek(0, "R13", 8'h01);
    cyc(1, 0, 1, 1, 8'h00);       // R2: hardware set meets software clear
    peek(1, "R2", 8'h80);
    rd_i = 0; peek(0, "R13", 0); rd_i = 1;

    cur_req = "mix R1 R2 R4 R7 R9";
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 6) cyc(0, 1'($urandom_range(0, 1)), 1, 1, 8'($urandom));
      else if (r < 12) cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1, 0, 8'($urandom_range(0, 4)));
      else if (r == 12) cyc(1, 0, 0, 0, 0, 1);
      else if (r == 13) cyc(1, 0, 0, 0, 0, 0, 0);
      else cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end
    cyc(0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule